// File: doc/BRIEF.md
# Serial Command Register Port

This block is the control-register port of a converter, seen from a host as a synchronous serial slave. The host lowers an active-low select, clocks in an 8-bit command byte MSB first, and then either clocks in 32 data bits for a write or clocks out 32 bits of the addressed register for a read. Once a transfer of one register is complete, the port waits again for a command byte. Raising the select at any point drops a partial transfer and returns the port to that same waiting state.

Three registers can be read and written: an offset word, a gain word and a configuration word. A fourth value, the conversion result, comes in on an input port and can only be read. The configuration word carries a software reset handshake. Writing its reset bit restores every register default and raises a reset-valid flag. The flag stays up until the configuration word is read. A later write clears the reset bit. Any other configuration bits take effect only through a write made after that one.

The serial pins are sampled into the system clock domain, and the system clock must run at least eight times faster than the serial clock. The serial port carries no handshake beyond the select and the serial clock, so there is no back-pressure. The host sets the pace of every bit, and a read is always served in full.

Top module: `conv_ctrl_port`

## Requirements
- R1: Command 0x01 followed by 32 bits loads the offset register, and command 0x09 reads it back.
- R2: Command 0x02 followed by 32 bits loads the gain register, and command 0x0A reads it back. For example, 0x02 then 0x80000000 gives a gain of 0x80000000.
- R3: Read data leaves on sdo MSB first. Each bit changes after a falling serial-clock edge, so the host samples it on the next rising edge. At all other times sdo is 0, including during command bytes and write data.
- R4: After the 32nd data bit of a read or a write, the next 8 bits are taken as a new command byte, with no idle time needed in between.
- R5: Command 0x03 writes the configuration word and command 0x0B reads it. Only the 15 bits in mask 0xFA0FF800 are kept, and every other bit reads 0. Bit 28 is the reset-valid flag and cannot be written.
- R6: Command 0x0C returns the conv_data input as it stands when the command byte completes. Any byte other than the seven listed command codes is ignored and the port keeps waiting for a command. This includes 0x04, which would be a write to the conversion data.
- R7: A configuration write with bit 29 (reset) set restores the defaults offset 0x00000000 and gain 0x01000000. It makes the configuration word exactly 0x30000000, with only the reset and reset-valid bits set, and drops all other data bits.
- R8: While bit 29 is set, a configuration write clears it and keeps all other writable bits at 0. A later write then sets bits normally.
- R9: A configuration read clears bit 28 (reset-valid) once its value has been captured for output.
- R10: After rst_n the configuration is 0x00000000, the offset is 0x00000000, the gain is 0x01000000 and sdo is 0.
- R11: Raising cs_n during a command byte or a data phase discards the partial transfer. No register changes, and the port returns to waiting for a command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select; high aborts any transfer |
| sdi | input | 1 | Serial data in, sampled on the rising sclk edge |
| sdo | output | 1 | Serial data out, changes after the falling sclk edge |
| conv_data | input | 32 | Current conversion result |
| offset_o | output | 32 | Offset register |
| gain_o | output | 32 | Gain register |
| cfg_o | output | 32 | Configuration register |

## Verification
Some properties are checked on every cycle. The unused configuration bits stay zero. While the reset bit is set, the configuration word holds nothing else besides the reset-valid flag. A reset write leaves the defaults in place on the following cycle. A configuration read clears the flag. sdo stays low outside a read. A register write is only issued as the port returns to command mode. A raised select forces command mode on the next cycle. The serial scenarios are needed to show the rest. These cover bit order and readback values, ignored command codes and the bytes that follow them, the two-step reset handshake, and aborts part-way through a byte or a data word.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam int CMD_W = 8;

  typedef enum logic [1:0] {
    SEL_OFF  = 2'd0,
    SEL_GAIN = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_CONV = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     ok;
    logic     wr;
    reg_sel_e sel;
  } cmd_dec_t;

  localparam int BIT_PSS = 31;
  localparam int BIT_PDN = 30;
  localparam int BIT_RST = 29;
  localparam int BIT_RV  = 28;
  localparam int BIT_SHT = 27;
  localparam int BIT_REF = 25;

  function automatic cmd_dec_t decode_cmd(input logic [CMD_W-1:0] b);
    cmd_dec_t d;
    d = '{ok: 1'b1, wr: 1'b0, sel: SEL_OFF};
    case (b)
      8'h01: d = '{ok: 1'b1, wr: 1'b1, sel: SEL_OFF};
      8'h02: d = '{ok: 1'b1, wr: 1'b1, sel: SEL_GAIN};
      8'h03: d = '{ok: 1'b1, wr: 1'b1, sel: SEL_CFG};
      8'h09: d = '{ok: 1'b1, wr: 1'b0, sel: SEL_OFF};
      8'h0A: d = '{ok: 1'b1, wr: 1'b0, sel: SEL_GAIN};
      8'h0B: d = '{ok: 1'b1, wr: 1'b0, sel: SEL_CFG};
      8'h0C: d = '{ok: 1'b1, wr: 1'b0, sel: SEL_CONV};
      default: d.ok = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= rst_val;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/scp_engine.sv
module scp_engine
  import scp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          cs_n_s,
  input  logic          sdi_s,
  input  logic [DW-1:0] rd_val,
  output logic          wr_en,
  output reg_sel_e      wr_sel,
  output logic [DW-1:0] wr_data,
  output reg_sel_e      rd_sel,
  output logic          rd_cfg,
  output logic          sdo
);
  localparam int CNTW = $clog2(DW);

  typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD} st_e;

  st_e            state;
  logic [CNTW-1:0] cnt;
  logic [DW-1:0]   sh, tx;
  logic            sclk_d;
  logic            rise, fall, last_cmd, last_dat, load;
  logic [DW-1:0]   sh_nx;
  cmd_dec_t        dec;

  assign rise     = sclk_s & ~sclk_d & ~cs_n_s;
  assign fall     = ~sclk_s & sclk_d & ~cs_n_s;
  assign sh_nx    = {sh[DW-2:0], sdi_s};
  assign dec      = decode_cmd(sh_nx[CMD_W-1:0]);
  assign last_cmd = (cnt == CNTW'(CMD_W-1));
  assign last_dat = (cnt == CNTW'(DW-1));
  assign load     = rise && state == ST_CMD && last_cmd && dec.ok && !dec.wr;
  assign rd_sel   = dec.sel;
  assign rd_cfg   = load && dec.sel == SEL_CFG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_CMD;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      sdo     <= 1'b0;
      wr_en   <= 1'b0;
      wr_sel  <= SEL_OFF;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (cs_n_s) begin
        state <= ST_CMD;
        cnt   <= '0;
        sdo   <= 1'b0;
      end else begin
        if (rise) begin
          sh <= sh_nx;
          unique case (state)
            ST_CMD: begin
              if (last_cmd) begin
                cnt <= '0;
                if (dec.ok && dec.wr) begin
                  state  <= ST_WR;
                  wr_sel <= dec.sel;
                end else if (dec.ok) begin
                  state <= ST_RD;
                  tx    <= rd_val;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            ST_WR: begin
              cnt <= cnt + 1'b1;
              if (last_dat) begin
                state   <= ST_CMD;
                wr_en   <= 1'b1;
                wr_data <= sh_nx;
              end
            end
            ST_RD: begin
              cnt <= cnt + 1'b1;
              if (last_dat) begin
                state <= ST_CMD;
                sdo   <= 1'b0;
              end
            end
            default: state <= ST_CMD;
          endcase
        end else if (fall && state == ST_RD) begin
          sdo <= tx[DW-1];
          tx  <= {tx[DW-2:0], 1'b0};
        end
      end
    end
  end

  // R3: sdo quiet outside a read
  a_r3_sdo_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RD) |-> (sdo == 1'b0));
  // R4: a register write is issued only as the port returns to command mode
  a_r4_wr_at_return: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (state == ST_CMD && cnt == '0));
  // R11: raised select forces command mode
  a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (state == ST_CMD && cnt == '0 && !wr_en));
endmodule

// File: rtl/scp_regs.sv
module scp_regs
  import scp_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [31:0] CFG_MASK = 32'hFA0F_F800,
  parameter logic [31:0] GAIN_DEF = 32'h0100_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  reg_sel_e      wr_sel,
  input  logic [DW-1:0] wr_data,
  input  reg_sel_e      rd_sel,
  input  logic          rd_cfg,
  input  logic [DW-1:0] conv_data,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] offset_q,
  output logic [DW-1:0] gain_q,
  output logic [DW-1:0] cfg_q
);
  localparam logic [DW-1:0] RV_M   = DW'(1) << BIT_RV;
  localparam logic [DW-1:0] RST_M  = DW'(1) << BIT_RST;
  localparam logic [DW-1:0] MASK   = DW'(CFG_MASK);
  localparam logic [DW-1:0] WMASK  = MASK & ~RV_M;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= '0;
      gain_q   <= DW'(GAIN_DEF);
      cfg_q    <= '0;
    end else begin
      if (wr_en) begin
        unique case (wr_sel)
          SEL_OFF:  offset_q <= wr_data;
          SEL_GAIN: gain_q   <= wr_data;
          SEL_CFG: begin
            if (wr_data[BIT_RST]) begin
              offset_q <= '0;
              gain_q   <= DW'(GAIN_DEF);
              cfg_q    <= RST_M | RV_M;
            end else if (cfg_q[BIT_RST]) begin
              cfg_q <= cfg_q & RV_M;
            end else begin
              cfg_q <= (wr_data & WMASK) | (cfg_q & RV_M);
            end
          end
          default: ;
        endcase
      end
      if (rd_cfg) cfg_q[BIT_RV] <= 1'b0;
    end
  end

  always_comb begin
    unique case (rd_sel)
      SEL_OFF:  rd_val = offset_q;
      SEL_GAIN: rd_val = gain_q;
      SEL_CFG:  rd_val = cfg_q;
      default:  rd_val = conv_data;
    endcase
  end

  // R5: unimplemented bits never hold a one
  a_r5_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q & ~MASK) == '0);
  // R7: reset bit stands alone
  a_r7_rst_alone: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[BIT_RST] |-> ((cfg_q & ~(RST_M | RV_M)) == '0));
  // R7: reset write restores defaults
  a_r7_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CFG && wr_data[BIT_RST]) |=>
      (offset_q == '0 && gain_q == DW'(GAIN_DEF) && cfg_q == (RST_M | RV_M)));
  // R9: configuration read drops reset-valid
  a_r9_rv_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cfg |=> !cfg_q[BIT_RV]);
endmodule

// File: rtl/conv_ctrl_port.sv
module conv_ctrl_port
  import scp_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          SYNC_N   = 2,
  parameter logic [31:0] CFG_MASK = 32'hFA0F_F800,
  parameter logic [31:0] GAIN_DEF = 32'h0100_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdi,
  output logic          sdo,
  input  logic [DW-1:0] conv_data,
  output logic [DW-1:0] offset_o,
  output logic [DW-1:0] gain_o,
  output logic [DW-1:0] cfg_o
);
  logic [2:0]    pins_s;
  logic          wr_en, rd_cfg;
  reg_sel_e      wr_sel, rd_sel;
  logic [DW-1:0] wr_data, rd_val;

  scp_sync #(.W(3), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_val(3'b010),
    .d({sclk, cs_n, sdi}), .q(pins_s)
  );

  scp_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[2]), .cs_n_s(pins_s[1]), .sdi_s(pins_s[0]),
    .rd_val(rd_val), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_cfg(rd_cfg), .sdo(sdo)
  );

  scp_regs #(.DW(DW), .CFG_MASK(CFG_MASK), .GAIN_DEF(GAIN_DEF)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_cfg(rd_cfg), .conv_data(conv_data),
    .rd_val(rd_val), .offset_q(offset_o), .gain_q(gain_o), .cfg_q(cfg_o)
  );
endmodule

// File: tb/conv_ctrl_port_test.sv
`timescale 1ns/1ps
module conv_ctrl_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic        sdo;
  logic [31:0] conv_data = '0;
  logic [31:0] offset_o, gain_o, cfg_o;

  int checks = 0;
  int errors = 0;
  logic sdo_seen;
  localparam int HALF = 6;

  always #10 clk = ~clk;

  conv_ctrl_port uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
    .conv_data(conv_data), .offset_o(offset_o), .gain_o(gain_o), .cfg_o(cfg_o)
  );

  // {write cmd, write data, read cmd, expected readback}
  localparam logic [79:0] VEC [5] = '{
    80'h01_12345678_09_12345678,
    80'h02_80000000_0A_80000000,
    80'h03_DFFFFFFF_0B_CA0FF800,
    80'h03_08000000_0B_08000000,
    80'h01_FFFFFFFF_09_FFFFFFFF
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0;
      sdi  = v[i];
      wait_clk(HALF);
      sdo_seen = sdo_seen | sdo;
      sclk = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic read_word(output logic [31:0] r);
    r = '0;
    for (int i = 0; i < 32; i++) begin
      sclk = 1'b0;
      sdi  = 1'b0;
      wait_clk(HALF);
      r = {r[30:0], sdo};
      sclk = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic wr_reg(input logic [7:0] c, input logic [31:0] d);
    send_bits({24'h0, c}, 8);
    send_bits(d, 32);
  endtask

  task automatic rd_reg(input logic [7:0] c, output logic [31:0] r);
    send_bits({24'h0, c}, 8);
    read_word(r);
  endtask

  task automatic abort_port();
    sclk = 1'b0;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(8);
    cs_n = 1'b0;
    wait_clk(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    check("R10 sdo after reset", {31'h0, sdo}, 32'h0);
    cs_n = 1'b0;
    wait_clk(8);
    rd_reg(8'h0B, r); check("R10 cfg default", r, 32'h0);
    rd_reg(8'h09, r); check("R10 offset default", r, 32'h0);
    rd_reg(8'h0A, r); check("R10 gain default", r, 32'h0100_0000);

    for (int v = 0; v < 5; v++) begin
      wr_reg(VEC[v][79:72], VEC[v][71:40]);
      rd_reg(VEC[v][39:32], r);
      check($sformatf("R1 R2 R4 R5 vector %0d", v), r, VEC[v][31:0]);
    end

    conv_data = 32'hCAFE_F00D;
    rd_reg(8'h0C, r); check("R6 conv read", r, 32'hCAFE_F00D);
    wr_reg(8'h01, 32'h1111_1111);
    wr_reg(8'h04, 32'hFFFF_FFFF);
    rd_reg(8'h09, r); check("R6 code 04 ignored offset", r, 32'h1111_1111);
    rd_reg(8'h0C, r); check("R6 conv after 04", r, 32'hCAFE_F00D);

    sdo_seen = 1'b0;
    wr_reg(8'h02, 32'hFFFF_FFFF);
    check("R3 sdo low during write", {31'h0, sdo_seen}, 32'h0);
    rd_reg(8'h0A, r); check("R2 gain all ones", r, 32'hFFFF_FFFF);

    wr_reg(8'h03, 32'hFFFF_FFFF);
    rd_reg(8'h0B, r); check("R7 cfg after reset write", r, 32'h3000_0000);
    rd_reg(8'h0B, r); check("R9 reset-valid cleared", r, 32'h2000_0000);
    rd_reg(8'h09, r); check("R7 offset restored", r, 32'h0);
    rd_reg(8'h0A, r); check("R7 gain restored", r, 32'h0100_0000);

    wr_reg(8'h03, 32'hC800_0000);
    rd_reg(8'h0B, r); check("R8 first write only clears reset", r, 32'h0);
    wr_reg(8'h03, 32'hC800_0000);
    rd_reg(8'h0B, r); check("R8 second write sets bits", r, 32'hC800_0000);

    send_bits(32'h01, 8);
    send_bits(32'hABCD, 16);
    abort_port();
    rd_reg(8'h09, r); check("R11 abort in data phase", r, 32'h0);
    send_bits(32'h0, 4);
    abort_port();
    rd_reg(8'h0A, r); check("R11 abort mid command", r, 32'h0100_0000);
    check("R3 sdo idle at end", {31'h0, sdo}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule